// File: doc/BRIEF.md
# Sticky-Enable Watchdog Register Block

This block is a watchdog timer that sits in a small register block on a simple 32-bit read/write bus. Software arms it by setting one bit of a control register. After that the watchdog cannot be switched off by software. Every write to the control register restarts the countdown, whatever data it carries. A 4-bit field in the same register sets the timeout in whole seconds. A prescaler divides the clock down to a one-second tick, and a seconds counter counts down on each tick.

When the countdown runs out, the block raises a reset request for a fixed number of clock cycles. It then drops the arming and returns to idle. At the moment of expiry it also sets a reset-cause flag. That flag is cleared only by the power-on reset or by an explicit write-one-to-clear from software, so software can tell after reboot that the watchdog fired. A read-only identification register returns a firmware version number.

The bus has no back-pressure. A read or write is accepted in every cycle in which its strobe is high. A read returns its data one cycle later, flagged by a read-valid pulse. Reads and writes may be issued in the same cycle.

Top module: `wdt_regblock`

## Requirements
- R1: After por_n is released, rst_req is low, the control register reads 0, the cause register reads 0, and the identification register reads FW_VERSION in bits 15:0 with 0 in bits 31:16.
- R2: Registers sit at byte addresses 0x14 (control), 0x1C (identification) and 0x20 (cause). rdata and rd_valid respond in the cycle after rd_en is sampled. Any other address reads 0. Writes to the identification register change nothing.
- R3: Writing 1 to control bit 7 arms the watchdog, and bit 7 reads back 1. A later write with bit 7 at 0 neither disarms it nor clears the bit. Only por_n or the end of a reset pulse clears it.
- R4: Control bits 11:8 give the timeout T in seconds, and a field value of 0 is taken as 1. While armed, rst_req rises T*TICK_CYCLES cycles after the last control write was sampled.
- R5: Any control write reloads the countdown from the timeout field of that same write, whatever else it carries, including when bit 7 is 0.
- R6: rst_req stays high for exactly RST_PULSE_CYCLES cycles. Afterwards control bit 7 reads 0 and no further request occurs. A control write made during the pulse neither lengthens the pulse nor re-arms the watchdog.
- R7: Cause register bit 31 is set on expiry and stays set through the reset pulse and through later writes of 0 to bit 31. It is cleared by writing 1 to bit 31 or by por_n.
- R8: Control bits other than bit 7 read back exactly the value last written.
- R9: While not armed, the block never raises rst_req, no matter how long it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe, accepted every cycle |
| rd_en | input | 1 | Read strobe, accepted every cycle |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High in the cycle after a read is accepted |
| rst_req | output | 1 | System reset request pulse |

## Verification
The hardest case to reach is a control write that lands while the reset pulse is already high. The write must neither stretch the pulse nor leave the watchdog armed once the pulse ends. The bench lets the countdown expire from a write of all zeros, which also exercises the zero-means-one-second rule. It then issues an arming write in the second cycle of the pulse and checks that the pulse still ends on schedule. Finally it watches the output for a long quiet stretch and reads the enable bit back as 0. Chains of kicks with bit 7 cleared keep the countdown from expiring, which shows that the enable is sticky and that every write reloads the countdown.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W    = 32;
  localparam int EN_BIT    = 7;
  localparam int TMO_LSB   = 8;
  localparam int TMO_W     = 4;
  localparam int CAUSE_BIT = 31;
  localparam int ID_W      = 16;

  localparam logic [7:0] OFS_CTRL  = 8'h14;
  localparam logic [7:0] OFS_ID    = 8'h1C;
  localparam logic [7:0] OFS_CAUSE = 8'h20;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_ID,
    SEL_CAUSE
  } reg_sel_e;

  // A zero timeout field counts as one second so expiry is never immediate.
  function automatic logic [TMO_W-1:0] eff_tmo(input logic [TMO_W-1:0] fld);
    return (fld == '0) ? TMO_W'(1) : fld;
  endfunction
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int TICK_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(TICK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (restart || tick) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!por_n)
    cnt_q <= LAST);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown import wdt_pkg::*; #(
  parameter int TICK_CYCLES      = 100_000_000,
  parameter int RST_PULSE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             armed,
  input  logic             kick,
  input  logic [TMO_W-1:0] kick_tmo,
  output logic             expire,
  output logic             pulse_done,
  output logic             rst_req
);
  localparam int PW = $clog2(RST_PULSE_CYCLES + 1);

  logic [TMO_W-1:0] secs_q;
  logic [PW-1:0]    pulse_q;
  logic             rst_q;
  logic             run;
  logic             tick;

  assign run        = armed && !rst_q;
  assign expire     = run && !kick && tick && (secs_q <= TMO_W'(1));
  assign pulse_done = rst_q && (pulse_q == '0);
  assign rst_req    = rst_q;

  wdt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk     (clk),
    .por_n   (por_n),
    .run     (run),
    .restart (kick || rst_q),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      secs_q  <= '0;
      pulse_q <= '0;
      rst_q   <= 1'b0;
    end else if (rst_q) begin
      if (pulse_q == '0) begin
        rst_q  <= 1'b0;
        secs_q <= '0;
      end else begin
        pulse_q <= pulse_q - 1'b1;
      end
    end else if (kick) begin
      secs_q <= eff_tmo(kick_tmo);
    end else if (expire) begin
      rst_q   <= 1'b1;
      pulse_q <= PW'(RST_PULSE_CYCLES - 1);
      secs_q  <= '0;
    end else if (run && tick) begin
      secs_q <= secs_q - 1'b1;
    end
  end

  assert_secs_loaded_R4: assert property (@(posedge clk) disable iff (!por_n)
    run |-> (secs_q != '0));

  assert_pulse_freeze_R6: assert property (@(posedge clk) disable iff (!por_n)
    (rst_q && !pulse_done) |=> rst_q);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter int          ADDR_W     = 8,
  parameter logic [15:0] FW_VERSION = 16'h0102
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  input  logic              pulse_done,
  output logic              kick,
  output logic [TMO_W-1:0]  kick_tmo,
  output logic              armed,
  output logic              cause,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] ctrl_q;
  logic              cause_q;
  logic              wr_cause_clr;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if (addr == ADDR_W'(OFS_CTRL))       sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFS_ID))    sel = SEL_ID;
    else if (addr == ADDR_W'(OFS_CAUSE)) sel = SEL_CAUSE;
    else                                 sel = SEL_NONE;
  end

  assign kick         = wr_en && (sel == SEL_CTRL);
  assign kick_tmo     = wdata[TMO_LSB +: TMO_W];
  assign wr_cause_clr = wr_en && (sel == SEL_CAUSE) && wdata[CAUSE_BIT];
  assign armed        = ctrl_q[EN_BIT];
  assign cause        = cause_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl_q <= '0;
    end else begin
      if (kick) begin
        ctrl_q         <= wdata;
        ctrl_q[EN_BIT] <= wdata[EN_BIT] | ctrl_q[EN_BIT];
      end
      if (pulse_done) begin
        ctrl_q[EN_BIT] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause_q <= 1'b0;
    end else if (expire) begin
      cause_q <= 1'b1;
    end else if (wr_cause_clr) begin
      cause_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL:  rd_mux = ctrl_q;
      SEL_ID:    rd_mux = {{(DATA_W-ID_W){1'b0}}, FW_VERSION};
      SEL_CAUSE: rd_mux[CAUSE_BIT] = cause_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assert_sticky_enable_R3: assert property (@(posedge clk) disable iff (!por_n)
    (armed && !pulse_done) |=> armed);

  assert_cause_kept_R7: assert property (@(posedge clk) disable iff (!por_n)
    (cause_q && !wr_cause_clr) |=> cause_q);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!por_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/wdt_regblock.sv
module wdt_regblock import wdt_pkg::*; #(
  parameter int          ADDR_W           = 8,
  parameter int          TICK_CYCLES      = 100_000_000,
  parameter int          RST_PULSE_CYCLES = 16,
  parameter logic [15:0] FW_VERSION       = 16'h0102
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output logic              rst_req
);
  localparam int HW = $clog2(RST_PULSE_CYCLES + 2);

  logic             kick;
  logic [TMO_W-1:0] kick_tmo;
  logic             armed;
  logic             cause;
  logic             expire;
  logic             pulse_done;

  wdt_regs #(.ADDR_W(ADDR_W), .FW_VERSION(FW_VERSION)) u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .expire     (expire),
    .pulse_done (pulse_done),
    .kick       (kick),
    .kick_tmo   (kick_tmo),
    .armed      (armed),
    .cause      (cause),
    .rdata      (rdata),
    .rd_valid   (rd_valid)
  );

  wdt_countdown #(
    .TICK_CYCLES      (TICK_CYCLES),
    .RST_PULSE_CYCLES (RST_PULSE_CYCLES)
  ) u_count (
    .clk        (clk),
    .por_n      (por_n),
    .armed      (armed),
    .kick       (kick),
    .kick_tmo   (kick_tmo),
    .expire     (expire),
    .pulse_done (pulse_done),
    .rst_req    (rst_req)
  );

  // Length of the current high stretch of rst_req, for the pulse-width check.
  logic [HW-1:0] hi_len_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       hi_len_q <= '0;
    else if (rst_req) hi_len_q <= hi_len_q + 1'b1;
    else              hi_len_q <= '0;
  end

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_req) |-> (hi_len_q == HW'(RST_PULSE_CYCLES)));

  assert_cause_on_expiry_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req) |-> cause);

  assert_only_when_armed_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req) |-> $past(armed));

  assert_kick_defers_R5: assert property (@(posedge clk) disable iff (!por_n)
    (kick && !rst_req) |=> !rst_req);
endmodule

// File: tb/wdt_regblock_tb.sv
module wdt_regblock_tb;
  localparam int TICK  = 10;
  localparam int PULSE = 4;
  localparam logic [15:0] FWV = 16'hC3A5;
  localparam logic [7:0] A_CTRL = 8'h14, A_ID = 8'h1C, A_CAUSE = 8'h20;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic        rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wdt_regblock #(
    .ADDR_W(8), .TICK_CYCLES(TICK), .RST_PULSE_CYCLES(PULSE), .FW_VERSION(FWV)
  ) u_dut (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk("R2 rd_valid", {31'b0, rd_valid}, 32'd1);
    d = rdata;
  endtask

  task automatic quiet(input string req, input int cycles);
    int highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_req) highs++;
    end
    chk(req, highs, 0);
  endtask

  // Called right after the kicking write returns; expiry is due 'cycles' later.
  task automatic expect_expiry(input string req, input int cycles);
    quiet({req, " early"}, cycles - 1);
    @(negedge clk); chk({req, " rise"}, {31'b0, rst_req}, 32'd1);
    begin
      int lows = 0;
      for (int i = 0; i < PULSE - 1; i++) begin
        @(negedge clk);
        if (!rst_req) lows++;
      end
      chk("R6 pulse held", lows, 0);
    end
    @(negedge clk); chk("R6 pulse end", {31'b0, rst_req}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rst_req idle", {31'b0, rst_req}, 32'd0);
    bus_rd(A_CTRL, d);  chk("R1 ctrl reset", d, 32'h0);
    bus_rd(A_CAUSE, d); chk("R1 cause reset", d, 32'h0);
    bus_rd(A_ID, d);    chk("R1 id value", d, {16'h0, FWV});
    bus_rd(8'h18, d);   chk("R2 unmapped read", d, 32'h0);
  endtask

  task automatic t_unarmed();
    bus_wr(A_CTRL, 32'h0000_0100);
    quiet("R9 unarmed no reset", 4 * TICK);
  endtask

  task automatic t_arm_and_expire();
    logic [31:0] d;
    bus_wr(A_CTRL, 32'h5A5A_02D5);
    bus_rd(A_CTRL, d); chk("R8 R3 readback armed", d, 32'h5A5A_02D5);
    bus_wr(A_CTRL, 32'h5A5A_0255);
    expect_expiry("R4 R5 expiry 2s", 2 * TICK);
    bus_rd(A_CTRL, d); chk("R6 R8 disarmed after pulse", d, 32'h5A5A_0255);
    bus_rd(A_CAUSE, d); chk("R7 cause set", d, 32'h8000_0000);
    quiet("R6 no repeat", 3 * TICK);
  endtask

  task automatic t_kicks_and_pulse_write();
    logic [31:0] d;
    bus_wr(A_CTRL, 32'h0000_0380);
    for (int k = 0; k < 3; k++) begin
      quiet("R5 kept alive", 15);
      bus_wr(A_CTRL, 32'h00F0_0300 ^ k);
    end
    bus_rd(A_CTRL, d); chk("R3 still armed", d[7], 1'b1);
    bus_wr(A_CTRL, 32'h0000_0000);
    quiet("R4 zero field early", TICK - 1);
    @(negedge clk); chk("R4 zero field is 1s", {31'b0, rst_req}, 32'd1);
    bus_wr(A_CTRL, 32'h0000_0380);
    @(negedge clk); chk("R6 write in pulse held", {31'b0, rst_req}, 32'd1);
    @(negedge clk); chk("R6 write in pulse end", {31'b0, rst_req}, 32'd0);
    quiet("R6 not re-armed", 4 * TICK);
    bus_rd(A_CTRL, d); chk("R6 enable cleared", d, 32'h0000_0300);
  endtask

  task automatic t_por_clears();
    logic [31:0] d;
    bus_wr(A_CTRL, 32'h0000_0F80);
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    bus_rd(A_CTRL, d);  chk("R3 por disarms", d, 32'h0);
    bus_rd(A_CAUSE, d); chk("R7 por clears cause", d, 32'h0);
    quiet("R3 quiet after por", 3 * TICK);
  endtask

  task automatic t_cause_and_id();
    logic [31:0] d;
    bus_wr(A_CTRL, 32'h0000_0180);
    expect_expiry("R4 expiry 1s", TICK);
    bus_wr(A_CAUSE, 32'h7FFF_FFFF);
    bus_rd(A_CAUSE, d); chk("R7 write 0 keeps cause", d, 32'h8000_0000);
    bus_wr(A_CAUSE, 32'h8000_0000);
    bus_rd(A_CAUSE, d); chk("R7 w1c clears cause", d, 32'h0);
    bus_wr(A_ID, 32'hFFFF_FFFF);
    bus_rd(A_ID, d); chk("R2 id write ignored", d, {16'h0, FWV});
    quiet("R2 id write no kick effect", 2 * TICK);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_reset();
    t_unarmed();
    t_arm_and_expire();
    t_kicks_and_pulse_write();
    t_por_clears();
    t_cause_and_id();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule